// File: doc/BRIEF.md
# Configuration Item DMA Engine

This engine lets a host move the contents of a configuration item into memory without going through the byte-wide data port. The host writes the 64-bit address of a descriptor that sits in memory. The address is written as two 32-bit halves: the upper half goes in first, and writing the lower half starts the engine. The engine then reads the descriptor, which holds four big-endian 32-bit words: a control word, a byte count, and the upper and lower halves of a target address.

Depending on the control bits, the engine can first select a new item. It then either copies bytes from the item into memory at the target address, or advances the item offset without moving any data. When it is done, it writes the result back into the descriptor's control word.

The item store, with its selector and its offset, sits outside this block and is shared with the register port. The engine reaches it through three one-cycle strobes:
- a selector load;
- a single-byte consume;
- an offset skip.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset, `busy` is 0, `mem_req` is 0, no store strobe is active, and `reg_rdata` returns the idle signature 0x51454D5520434647.
- R2: A write with `reg_lo`=0 while idle loads the upper address half and starts nothing. `reg_rdata` then shows {upper, 32'h0}. Whenever the held address is nonzero and no operation is running, `reg_rdata` shows the held address instead of the signature.
- R3: A write with `reg_lo`=1 while idle starts an operation, and `busy` is high from the next cycle. While busy, `reg_rdata` returns the full 64-bit descriptor address.
- R4: Register writes made while `busy` is high are ignored. They do not change the held address and do not start another operation.
- R5: The engine fetches the descriptor as four 32-bit word reads (`mem_word`=1) at descriptor+0, +4, +8 and +12. Each word is taken big-endian from `mem_rdata`. The words are, in order: control, length, target[63:32], target[31:0].
- R6: If control bit 3 is set, exactly one `cfg_sel_we` pulse is issued, carrying `cfg_sel_key` = control[31:16]. This happens before any byte consume or skip.
- R7: If control bit 1 is set, the engine copies `length` bytes. For each byte i, it first pulses `cfg_byte_req` once, taking the value of `cfg_byte` in that cycle. It then makes a byte write (`mem_word`=0, data in `mem_wdata[7:0]`) to target+i. Bytes beyond the item's end arrive from the store as zeros and are written as zeros.
- R8: If control bit 2 is set and bit 1 is clear, exactly one `cfg_skip_we` pulse is issued with `cfg_skip_len` equal to the length, and no data is written. If bits 1 and 2 are both set, the copy takes place and no skip is issued.
- R9: A copy with length 0 makes no byte consumes and no data writes.
- R10: Each operation ends with a word write to descriptor+0 carrying the status: 0 on success. After that write is acknowledged, `busy` falls and the held address clears, so `reg_rdata` returns the signature again.
- R11: If `mem_err` comes back with the acknowledgement of any fetch or data write, the engine stops issuing data writes and store strobes and writes status 1 (control bit 0 set).
- R12: A memory request keeps `mem_req`, `mem_addr` and `mem_wdata` steady until it is acknowledged. At most one store strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Address register write strobe |
| reg_lo | input | 1 | 1 selects the lower half (offset 4, trigger); 0 selects the upper half (offset 0) |
| reg_wdata | input | 32 | Value written to the selected half |
| reg_rdata | output | 64 | Address register read value |
| busy | output | 1 | An operation is in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_word | output | 1 | 1 for a 32-bit access, 0 for a single byte |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 32 | Write data; a byte write uses bits 7:0 |
| mem_ack | input | 1 | Request completed (one-cycle pulse) |
| mem_err | input | 1 | Bus error, valid together with `mem_ack` |
| mem_rdata | input | 32 | Read word; the lowest address byte is in bits 31:24 |
| cfg_sel_we | output | 1 | Load the item selector and clear the offset |
| cfg_sel_key | output | 16 | Selector value |
| cfg_byte_req | output | 1 | Consume one byte at the current offset |
| cfg_byte | input | 8 | Byte at the current selector and offset |
| cfg_skip_we | output | 1 | Advance the offset by `cfg_skip_len` |
| cfg_skip_len | output | 32 | Skip amount in bytes |

## Verification
The assertions assume the memory side follows a single-cycle handshake. `mem_ack` pulses for exactly one cycle, only while `mem_req` is high, and `mem_err` is meaningful only alongside it. `cfg_byte` must reflect the store's current selector and offset, and the store must update those only at the clock edge where a strobe is sampled. The bench's memory responder raises `mem_ack` on the falling edge after it sees a request and drops it on the next falling edge. Its store model changes state only on rising edges, so the stimulus never acknowledges twice or moves the offset between the engine sampling a byte and consuming it.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 2 * WORD_W;
    localparam int KEY_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int DESC_WRDS = 4;
    localparam int IDX_W     = $clog2(DESC_WRDS);
    localparam int LANE_SH   = $clog2(WORD_W / BYTE_W);

    localparam logic [ADDR_W-1:0] IDLE_SIG = 64'h5145_4D55_2043_4647;

    // control word bit positions
    localparam int CB_ERR  = 0;
    localparam int CB_READ = 1;
    localparam int CB_SKIP = 2;
    localparam int CB_SEL  = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_SEL, ST_RD, ST_WR, ST_SKIP, ST_STAT
    } eng_st_e;

    typedef struct packed {
        eng_st_e           st;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] len;
        logic [ADDR_W-1:0] tgt;
        logic [ADDR_W-1:0] desc;
        logic [BYTE_W-1:0] data;
        logic              err;
    } eng_s;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } areg_s;
endpackage

// File: rtl/cfg_dma_addr_reg.sv
module cfg_dma_addr_reg
    import cfg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_lo,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              busy,
    input  logic              done,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] reg_rdata
);
    areg_s r_d, r_q;

    assign start      = reg_we && reg_lo && !busy;
    assign start_addr = {r_q.hi, reg_wdata};

    always_comb begin
        r_d = r_q;
        if (done) begin
            r_d = '0;
        end else if (reg_we && !busy) begin
            if (reg_lo) r_d.lo = reg_wdata;
            else        r_d.hi = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reg_rdata = (busy || (r_q != '0)) ? {r_q.hi, r_q.lo} : IDLE_SIG;

    p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (reg_rdata == IDLE_SIG));

    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && !done) |=> (r_q == $past(r_q)));
endmodule

// File: rtl/cfg_dma_seq.sv
module cfg_dma_seq
    import cfg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              cfg_sel_we,
    output logic [KEY_W-1:0]  cfg_sel_key,
    output logic              cfg_byte_req,
    input  logic [BYTE_W-1:0] cfg_byte,
    output logic              cfg_skip_we,
    output logic [WORD_W-1:0] cfg_skip_len
);
    eng_s r_d, r_q;

    function automatic eng_st_e pick_op(logic [WORD_W-1:0] c, logic [WORD_W-1:0] l);
        if (c[CB_READ]) return (l == '0) ? ST_STAT : ST_RD;
        if (c[CB_SKIP]) return ST_SKIP;
        return ST_STAT;
    endfunction

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: if (start) begin
                r_d.st   = ST_FETCH;
                r_d.desc = start_addr;
                r_d.idx  = '0;
                r_d.err  = 1'b0;
            end
            ST_FETCH: if (mem_ack) begin
                if (mem_err) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_STAT;
                end else begin
                    unique case (r_q.idx)
                        2'd0:    r_d.ctl = mem_rdata;
                        2'd1:    r_d.len = mem_rdata;
                        2'd2:    r_d.tgt[ADDR_W-1:WORD_W] = mem_rdata;
                        default: r_d.tgt[WORD_W-1:0] = mem_rdata;
                    endcase
                    if (r_q.idx == IDX_W'(DESC_WRDS - 1))
                        r_d.st = r_q.ctl[CB_SEL] ? ST_SEL : pick_op(r_q.ctl, r_q.len);
                    else
                        r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_SEL:  r_d.st = pick_op(r_q.ctl, r_q.len);
            ST_RD: begin
                r_d.data = cfg_byte;
                r_d.st   = ST_WR;
            end
            ST_WR: if (mem_ack) begin
                if (mem_err) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_STAT;
                end else begin
                    r_d.tgt = r_q.tgt + 1'b1;
                    r_d.len = r_q.len - 1'b1;
                    r_d.st  = (r_q.len == WORD_W'(1)) ? ST_STAT : ST_RD;
                end
            end
            ST_SKIP: r_d.st = ST_STAT;
            ST_STAT: if (mem_ack) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign busy         = (r_q.st != ST_IDLE);
    assign done         = (r_q.st == ST_STAT) && mem_ack;
    assign mem_req      = (r_q.st == ST_FETCH) || (r_q.st == ST_WR) || (r_q.st == ST_STAT);
    assign mem_we       = (r_q.st != ST_FETCH);
    assign mem_word     = (r_q.st != ST_WR);
    assign cfg_sel_we   = (r_q.st == ST_SEL);
    assign cfg_sel_key  = r_q.ctl[WORD_W-1 -: KEY_W];
    assign cfg_byte_req = (r_q.st == ST_RD);
    assign cfg_skip_we  = (r_q.st == ST_SKIP);
    assign cfg_skip_len = r_q.len;

    always_comb begin
        mem_addr  = r_q.desc;
        mem_wdata = '0;
        if (r_q.st == ST_FETCH) begin
            mem_addr = r_q.desc + (ADDR_W'(r_q.idx) << LANE_SH);
        end else if (r_q.st == ST_WR) begin
            mem_addr  = r_q.tgt;
            mem_wdata = WORD_W'(r_q.data);
        end else if (r_q.st == ST_STAT) begin
            mem_wdata[CB_ERR] = r_q.err;
        end
    end

    p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_sel_we, cfg_byte_req, cfg_skip_we}));

    p_consume_then_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_byte_req |=> (mem_req && mem_we && !mem_word));
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
    import cfg_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_lo,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              cfg_sel_we,
    output logic [KEY_W-1:0]  cfg_sel_key,
    output logic              cfg_byte_req,
    input  logic [BYTE_W-1:0] cfg_byte,
    output logic              cfg_skip_we,
    output logic [WORD_W-1:0] cfg_skip_len
);
    logic              start, done;
    logic [ADDR_W-1:0] start_addr;

    cfg_dma_addr_reg i_areg (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_lo     (reg_lo),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .done       (done),
        .start      (start),
        .start_addr (start_addr),
        .reg_rdata  (reg_rdata)
    );

    cfg_dma_seq i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_addr   (start_addr),
        .busy         (busy),
        .done         (done),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_word     (mem_word),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_err      (mem_err),
        .mem_rdata    (mem_rdata),
        .cfg_sel_we   (cfg_sel_we),
        .cfg_sel_key  (cfg_sel_key),
        .cfg_byte_req (cfg_byte_req),
        .cfg_byte     (cfg_byte),
        .cfg_skip_we  (cfg_skip_we),
        .cfg_skip_len (cfg_skip_len)
    );

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && reg_rdata == $past(start_addr)));
endmodule

// File: tb/test_cfg_dma_engine.sv
`timescale 1ns/1ps
module test_cfg_dma_engine;
    localparam logic [63:0] SIG = 64'h5145_4D55_2043_4647;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_lo = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        busy, mem_req, mem_we, mem_word;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cfg_sel_we, cfg_byte_req, cfg_skip_we;
    logic [15:0] cfg_sel_key;
    logic [7:0]  cfg_byte;
    logic [31:0] cfg_skip_len;

    always #2 clk = ~clk;

    cfg_dma_engine i_cfg_dma_engine (.*);

    int checks = 0, errors = 0;
    logic [7:0]  mem [256];
    logic [63:0] err_addr = '1;
    int          wr_cnt, sel_cnt, cons_cnt, skip_cnt;
    logic [63:0] first_wr_addr;
    logic [15:0] last_key;
    logic [31:0] last_skip;
    logic [15:0] st_sel = '0;
    logic [31:0] st_off = '0;

    function automatic logic [7:0] item_byte(logic [15:0] k, logic [31:0] o);
        if (o < 32'(k[3:0]) + 32'd4) return k[7:0] ^ (o[7:0] * 8'd7 + 8'd1);
        return 8'h00;
    endfunction
    assign cfg_byte = item_byte(st_sel, st_off);

    // item store model: state changes on the rising edge only
    initial forever begin
        @(posedge clk);
        if (cfg_sel_we) begin
            st_sel <= cfg_sel_key; st_off <= '0; sel_cnt++; last_key = cfg_sel_key;
        end else if (cfg_byte_req) begin
            st_off <= st_off + 1; cons_cnt++;
        end else if (cfg_skip_we) begin
            st_off <= st_off + cfg_skip_len; skip_cnt++; last_skip = cfg_skip_len;
        end
    end

    // memory responder: one-cycle ack on the falling edge
    initial forever begin
        @(negedge clk);
        if (mem_ack) begin
            mem_ack = 1'b0; mem_err = 1'b0;
        end else if (mem_req) begin
            mem_ack = 1'b1;
            mem_err = (mem_addr == err_addr);
            if (!mem_err) begin
                if (!mem_we) begin
                    for (int i = 0; i < 4; i++) mem_rdata[31-8*i -: 8] = mem[8'(mem_addr) + 8'(i)];
                end else if (mem_word) begin
                    for (int i = 0; i < 4; i++) mem[8'(mem_addr) + 8'(i)] = mem_wdata[31-8*i -: 8];
                end else begin
                    if (wr_cnt == 0) first_wr_addr = mem_addr;
                    mem[8'(mem_addr)] = mem_wdata[7:0];
                    wr_cnt++;
                end
            end
        end
    end

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_word(logic [7:0] a);
        return {mem[a], mem[a+8'd1], mem[a+8'd2], mem[a+8'd3]};
    endfunction

    task automatic put_word(logic [7:0] a, logic [31:0] v);
        for (int i = 0; i < 4; i++) mem[a + 8'(i)] = v[31-8*i -: 8];
    endtask

    task automatic put_desc(logic [7:0] d, logic [31:0] ctl, logic [31:0] len, logic [63:0] tgt);
        put_word(d, ctl); put_word(d + 8'd4, len);
        put_word(d + 8'd8, tgt[63:32]); put_word(d + 8'd12, tgt[31:0]);
        wr_cnt = 0; sel_cnt = 0; cons_cnt = 0; skip_cnt = 0;
    endtask

    task automatic reg_write(bit lo, logic [31:0] v);
        @(negedge clk); reg_we = 1'b1; reg_lo = lo; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0; reg_lo = 1'b0;
    endtask

    task automatic trigger(logic [7:0] d);
        reg_write(1'b0, 32'h0);
        reg_write(1'b1, 32'(d));
    endtask

    task automatic wait_done();
        int n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        if (busy) check(1'b0, "watchdog", 64'(n), 64'd0);
    endtask

    task automatic t_reset();
        check(reg_rdata == SIG, "R1 signature", reg_rdata, SIG);
        check(!busy && !mem_req, "R1 idle", {busy, mem_req}, 0);
        check(!cfg_sel_we && !cfg_byte_req && !cfg_skip_we, "R1 strobes",
              {cfg_sel_we, cfg_byte_req, cfg_skip_we}, 0);
    endtask

    task automatic t_upper_half();
        reg_write(1'b0, 32'h1234_5678);
        check(reg_rdata == 64'h1234_5678_0000_0000, "R2 upper half", reg_rdata, 64'h1234_5678_0000_0000);
        check(!busy, "R2 no start", busy, 0);
        reg_write(1'b0, 32'h0);
        check(reg_rdata == SIG, "R2 cleared", reg_rdata, SIG);
    endtask

    task automatic t_select_read();
        mem[8'h85] = 8'hEE;
        put_desc(8'h10, 32'h0021_000A, 32'd5, 64'hA500_0000_0000_0080);
        trigger(8'h10);
        check(busy, "R3 busy", busy, 1);
        check(reg_rdata == 64'h10, "R3 readback", reg_rdata, 64'h10);
        wait_done();
        check(sel_cnt == 1 && last_key == 16'h0021, "R6 select", {sel_cnt, last_key}, {32'd1, 16'h0021});
        check(first_wr_addr == 64'hA500_0000_0000_0080, "R5 target", first_wr_addr, 64'hA500_0000_0000_0080);
        for (int i = 0; i < 5; i++)
            check(mem[8'h80 + 8'(i)] == item_byte(16'h21, 32'(i)), "R7 copy byte",
                  mem[8'h80 + 8'(i)], item_byte(16'h21, 32'(i)));
        check(mem[8'h85] == 8'hEE, "R7 bound", mem[8'h85], 8'hEE);
        check(wr_cnt == 5 && cons_cnt == 5, "R7 counts", {wr_cnt, cons_cnt}, {32'd5, 32'd5});
        check(rd_word(8'h10) == 0, "R10 status ok", rd_word(8'h10), 0);
        check(reg_rdata == SIG, "R10 signature back", reg_rdata, SIG);
    endtask

    task automatic t_past_end();
        put_desc(8'h20, 32'h0020_000A, 32'd6, 64'h90);
        mem[8'h94] = 8'hAA; mem[8'h95] = 8'hBB;
        trigger(8'h20); wait_done();
        check(mem[8'h93] == item_byte(16'h20, 3), "R7 last valid", mem[8'h93], item_byte(16'h20, 3));
        check(mem[8'h94] == 0 && mem[8'h95] == 0, "R7 zero fill", {mem[8'h94], mem[8'h95]}, 0);
    endtask

    task automatic t_skip_then_read();
        put_desc(8'h30, 32'h0022_000C, 32'd2, 64'hA0);
        trigger(8'h30); wait_done();
        check(skip_cnt == 1 && last_skip == 2, "R8 skip", {skip_cnt, last_skip}, {32'd1, 32'd2});
        check(wr_cnt == 0 && sel_cnt == 1, "R8 no data", {wr_cnt, sel_cnt}, {32'd0, 32'd1});
        put_desc(8'h30, 32'h0000_0002, 32'd3, 64'hA0);
        trigger(8'h30); wait_done();
        check(sel_cnt == 0, "R6 no select", sel_cnt, 0);
        for (int i = 0; i < 3; i++)
            check(mem[8'hA0 + 8'(i)] == item_byte(16'h22, 32'(i + 2)), "R8 offset kept",
                  mem[8'hA0 + 8'(i)], item_byte(16'h22, 32'(i + 2)));
    endtask

    task automatic t_read_and_skip();
        put_desc(8'h40, 32'h0023_000E, 32'd1, 64'hB0);
        trigger(8'h40); wait_done();
        check(skip_cnt == 0 && wr_cnt == 1, "R8 read wins", {skip_cnt, wr_cnt}, {32'd0, 32'd1});
    endtask

    task automatic t_len_zero();
        put_desc(8'h40, 32'h0000_0002, 32'd0, 64'hB0);
        trigger(8'h40); wait_done();
        check(wr_cnt == 0 && cons_cnt == 0, "R9 nothing moved", {wr_cnt, cons_cnt}, 0);
        check(rd_word(8'h40) == 0, "R9 status", rd_word(8'h40), 0);
    endtask

    task automatic t_fetch_err();
        put_desc(8'h50, 32'h0024_000A, 32'd3, 64'hC0);
        err_addr = 64'h58;
        trigger(8'h50); wait_done();
        err_addr = '1;
        check(wr_cnt == 0 && sel_cnt == 0 && cons_cnt == 0, "R11 fetch abort",
              {wr_cnt, sel_cnt, cons_cnt}, 0);
        check(rd_word(8'h50) == 1, "R11 fetch status", rd_word(8'h50), 1);
    endtask

    task automatic t_copy_err();
        put_desc(8'h60, 32'h0025_000A, 32'd4, 64'hD0);
        mem[8'hD2] = 8'h5A; mem[8'hD3] = 8'h5B;
        err_addr = 64'hD2;
        trigger(8'h60); wait_done();
        err_addr = '1;
        check(wr_cnt == 2 && mem[8'hD2] == 8'h5A && mem[8'hD3] == 8'h5B, "R11 copy abort",
              {wr_cnt, mem[8'hD2], mem[8'hD3]}, {32'd2, 8'h5A, 8'h5B});
        check(rd_word(8'h60) == 1, "R11 copy status", rd_word(8'h60), 1);
    endtask

    task automatic t_busy_ignore();
        put_desc(8'h70, 32'h0021_000A, 32'd3, 64'hE0);
        trigger(8'h70);
        reg_write(1'b0, 32'hFFFF_0000);
        check(reg_rdata == 64'h70, "R4 held address", reg_rdata, 64'h70);
        reg_write(1'b1, 32'h0000_0040);
        wait_done();
        repeat (4) @(negedge clk);
        check(!busy && reg_rdata == SIG, "R4 no restart", {busy, reg_rdata}, {1'b0, SIG});
        check(wr_cnt == 3 && first_wr_addr == 64'hE0, "R4 original op", {wr_cnt, first_wr_addr}, {32'd3, 64'hE0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_upper_half();
        t_select_read();
        t_past_end();
        t_skip_then_read();
        t_read_and_skip();
        t_len_zero();
        t_fetch_err();
        t_copy_err();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule